// File: doc/BRIEF.md
# Balanced-Symbol Radio Packet Framer

This block serialises one buffered packet for a half-duplex radio transmitter. On a start strobe it drives the transmitter enable low and sends a bit stream: an optional run of wake-up units, a square-wave preamble, an 8-bit frame sync, one 12-bit symbol for each packet byte, and then a checksum symbol. When the last bit has been sent it releases the enable and pulses a done flag. Each wake-up unit is a fixed number of preamble cycles followed by an 8-bit hold marker.

The packet sits in an external byte buffer. The framer reads the buffer through a read port that returns data one clock after the address. The first byte is the control byte, and its low five bits give the number of data bytes that follow. Every byte is mapped to a DC-balanced 12-bit codeword by a lookup table that is computed at elaboration. The bit clock is the system clock divided by a parameter.

Top module: `balsym_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, tx_en_n is 1, tx_data is 0 and done is 0. A start sampled while idle drives tx_en_n to 0 at the next clock edge. tx_en_n then stays 0 for exactly (frame bits × CLK_DIV) clocks.
- R2: Every bit is held for CLK_DIV clocks. Every field is sent most significant bit first.
- R3: The preamble is pre_cycles pairs of bits, each pair being 0 followed by 1. A pre_cycles value of 0 is sent as one pair.
- R4: When wake_units is nonzero, that many wake-up units come before the preamble. Each unit is HOLD_CYCLES pairs "0,1" followed by the hold marker 8'b0001_1011, which is the complement of the 7-bit Barker code with a balancing 1 added. When wake_units is 0, no wake-up unit is sent.
- R5: The frame sync 8'b1110_0100 follows the preamble. It is the 7-bit Barker code with a balancing 0 added.
- R6: Byte value k is sent as the k-th entry, counting in ascending numeric order, of the 12-bit values that have exactly six ones and no run longer than four equal bits, leaving out 12'h555 and 12'hAAA.
- R7: The byte at address 0 is the control byte. Data bytes follow from addresses 1 to N, where N is control bits [4:0] limited to MAX_BYTES. rd_data is taken to be valid one clock after rd_addr.
- R8: After the last data byte, the modulo-256 sum of the control byte and all sent data bytes is sent as a symbol.
- R9: done is high for exactly one clock, in the first clock in which tx_en_n is back at 1. tx_data is 0 whenever tx_en_n is 1.
- R10: A start that arrives during a frame has no effect on the stream or its length. The pre_cycles and wake_units values are taken only at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start strobe |
| pre_cycles | input | PRE_W | Preamble length in "01" pairs |
| wake_units | input | WAKE_W | Number of wake-up units |
| rd_addr | output | $clog2(MAX_BYTES+2) | Packet buffer read address |
| rd_data | input | 8 | Packet buffer read data, one clock latency |
| tx_data | output | 1 | Serial data to the transmitter |
| tx_en_n | output | 1 | Active-low transmitter enable |
| done | output | 1 | One-clock end-of-frame pulse |

## Verification
The bench builds the framer with CLK_DIV=4 and HOLD_CYCLES=6, and keeps MAX_BYTES at 27. With these values, frames that contain several hold markers finish within a few hundred bit periods. A full 27-byte packet behind the default 160-pair preamble, and a control byte that asks for 31 bytes and must be limited, also fit easily in the run. The bench builds the symbol table independently from the selection rule and predicts every bit of each frame. This covers wake-up units, a zero preamble count, an empty packet, a checksum that wraps, and a start pulse sent in the middle of a frame.

// File: rtl/balsym_pkg.sv
package balsym_pkg;

   localparam int SYM_W = 12;
   localparam logic [7:0] SYNC_PAT = 8'b1110_0100;
   localparam logic [7:0] HOLD_PAT = 8'b0001_1011;

   typedef enum logic [2:0] {
      PH_IDLE, PH_WAKE, PH_HOLD, PH_PRE, PH_SYNC, PH_DATA, PH_CKS
   } phase_t;

   function automatic int count_ones(logic [SYM_W-1:0] v);
      int n;
      n = 0;
      for (int i = 0; i < SYM_W; i++) n += int'(v[i]);
      return n;
   endfunction

   function automatic int longest_run(logic [SYM_W-1:0] v);
      int run;
      int best;
      run  = 1;
      best = 1;
      for (int i = 1; i < SYM_W; i++) begin
         if (v[i] == v[i-1]) run++;
         else run = 1;
         if (run > best) best = run;
      end
      return best;
   endfunction

   // Ascending scan of all 12-bit values; split into two 64-step loops.
   function automatic logic [255:0][SYM_W-1:0] build_sym_table();
      logic [255:0][SYM_W-1:0] t;
      logic [SYM_W-1:0] v;
      int k;
      t = '0;
      k = 0;
      for (int hi = 0; hi < 64; hi++) begin
         for (int lo = 0; lo < 64; lo++) begin
            v = SYM_W'(hi * 64 + lo);
            if (k < 256 && count_ones(v) == 6 && longest_run(v) <= 4 &&
                v != 12'h555 && v != 12'hAAA) begin
               t[k] = v;
               k++;
            end
         end
      end
      return t;
   endfunction

endpackage

// File: rtl/balsym_bit_timer.sv
module balsym_bit_timer #(
   parameter int CLK_DIV = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
   localparam bit POW2 = ((CLK_DIV & (CLK_DIV - 1)) == 0);

   logic [CW-1:0] cnt;

   generate
      if (POW2) begin : g_pow2
         assign tick = run && (&cnt);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    cnt <= '0;
            else if (!run) cnt <= '0;
            else           cnt <= cnt + 1'b1;
         end
      end else begin : g_mod
         assign tick = run && (cnt == CW'(CLK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (!run)  cnt <= '0;
            else if (tick)  cnt <= '0;
            else            cnt <= cnt + 1'b1;
         end
      end
   endgenerate

   assert_tick_wraps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (cnt == '0));

endmodule

// File: rtl/balsym_symbol_rom.sv
module balsym_symbol_rom
   import balsym_pkg::*;
(
   input  logic [7:0]       byte_in,
   output logic [SYM_W-1:0] sym
);
   localparam logic [255:0][SYM_W-1:0] TAB = build_sym_table();

   assign sym = TAB[byte_in];

   always_comb begin
      assert_sym_balanced_R6: assert (count_ones(sym) == 6);
      assert_sym_run_R6: assert (longest_run(sym) <= 4);
   end

endmodule

// File: rtl/balsym_framer.sv
module balsym_framer
   import balsym_pkg::*;
#(
   parameter int CLK_DIV     = 256,
   parameter int MAX_BYTES   = 27,
   parameter int HOLD_CYCLES = 256,
   parameter int PRE_W       = 8,
   parameter int WAKE_W      = 8,
   localparam int AW         = $clog2(MAX_BYTES + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [PRE_W-1:0]  pre_cycles,
   input  logic [WAKE_W-1:0] wake_units,
   output logic [AW-1:0]     rd_addr,
   input  logic [7:0]        rd_data,
   output logic              tx_data,
   output logic              tx_en_n,
   output logic              done
);
   localparam int HW    = $clog2(HOLD_CYCLES + 1);
   localparam int CYC_W = (PRE_W > HW) ? PRE_W : HW;

   generate
      if (CLK_DIV < 2) begin : g_bad_div
         $error("balsym_framer: CLK_DIV below 2 breaks the one-clock read prefetch");
      end
      if (MAX_BYTES < 1 || MAX_BYTES > 31) begin : g_bad_len
         $error("balsym_framer: MAX_BYTES must fit the 5-bit count field");
      end
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("balsym_framer: HOLD_CYCLES must be positive");
      end
   endgenerate

   logic              active;
   phase_t            phase;
   logic [SYM_W-1:0]  sh;
   logic [3:0]        bits_left;
   logic [CYC_W-1:0]  cyc_cnt;
   logic [WAKE_W-1:0] unit_cnt;
   logic [PRE_W-1:0]  pre_q;
   logic [WAKE_W-1:0] wake_q;
   logic [AW-1:0]     byte_idx;
   logic [AW-1:0]     n_data;
   logic [7:0]        csum;
   logic              tick;

   logic [CYC_W-1:0]  pre_lim;
   logic [AW-1:0]     n_next;
   logic              load_cks;
   logic [7:0]        rom_in;
   logic [SYM_W-1:0]  sym;

   balsym_bit_timer #(.CLK_DIV(CLK_DIV)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(active), .tick(tick)
   );

   balsym_symbol_rom u_rom (.byte_in(rom_in), .sym(sym));

   always_comb begin
      pre_lim  = (pre_q == '0) ? CYC_W'(1) : CYC_W'(pre_q);
      n_next   = (int'(rd_data[4:0]) > MAX_BYTES) ? AW'(MAX_BYTES) : AW'(rd_data[4:0]);
      load_cks = (phase == PH_DATA) && (byte_idx > n_data);
      rom_in   = load_cks ? csum : rd_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         phase     <= PH_IDLE;
         sh        <= '0;
         bits_left <= '0;
         cyc_cnt   <= '0;
         unit_cnt  <= '0;
         pre_q     <= '0;
         wake_q    <= '0;
         byte_idx  <= '0;
         n_data    <= '0;
         csum      <= '0;
         done      <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            if (start) begin
               active    <= 1'b1;
               pre_q     <= pre_cycles;
               wake_q    <= wake_units;
               byte_idx  <= '0;
               cyc_cnt   <= CYC_W'(1);
               unit_cnt  <= '0;
               csum      <= '0;
               sh        <= {2'b01, 10'b0};
               bits_left <= 4'd2;
               phase     <= (wake_units != '0) ? PH_WAKE : PH_PRE;
            end
         end else if (tick) begin
            if (bits_left != 4'd1) begin
               sh        <= {sh[SYM_W-2:0], 1'b0};
               bits_left <= bits_left - 4'd1;
            end else begin
               case (phase)
                  PH_WAKE: begin
                     if (cyc_cnt == CYC_W'(HOLD_CYCLES)) begin
                        phase     <= PH_HOLD;
                        sh        <= {HOLD_PAT, 4'b0};
                        bits_left <= 4'd8;
                     end else begin
                        cyc_cnt   <= cyc_cnt + 1'b1;
                        sh        <= {2'b01, 10'b0};
                        bits_left <= 4'd2;
                     end
                  end
                  PH_HOLD: begin
                     cyc_cnt   <= CYC_W'(1);
                     sh        <= {2'b01, 10'b0};
                     bits_left <= 4'd2;
                     if (unit_cnt + 1'b1 == wake_q) begin
                        phase <= PH_PRE;
                     end else begin
                        unit_cnt <= unit_cnt + 1'b1;
                        phase    <= PH_WAKE;
                     end
                  end
                  PH_PRE: begin
                     if (cyc_cnt >= pre_lim) begin
                        phase     <= PH_SYNC;
                        sh        <= {SYNC_PAT, 4'b0};
                        bits_left <= 4'd8;
                     end else begin
                        cyc_cnt   <= cyc_cnt + 1'b1;
                        sh        <= {2'b01, 10'b0};
                        bits_left <= 4'd2;
                     end
                  end
                  PH_SYNC: begin
                     phase     <= PH_DATA;
                     sh        <= sym;
                     bits_left <= 4'd12;
                     csum      <= rd_data;
                     n_data    <= n_next;
                     byte_idx  <= AW'(1);
                  end
                  PH_DATA: begin
                     sh        <= sym;
                     bits_left <= 4'd12;
                     if (load_cks) begin
                        phase <= PH_CKS;
                     end else begin
                        csum     <= csum + rd_data;
                        byte_idx <= byte_idx + 1'b1;
                     end
                  end
                  PH_CKS: begin
                     active <= 1'b0;
                     done   <= 1'b1;
                     phase  <= PH_IDLE;
                  end
                  default: phase <= PH_IDLE;
               endcase
            end
         end
      end
   end

   assign rd_addr = byte_idx;
   assign tx_en_n = ~active;
   assign tx_data = active & sh[SYM_W-1];

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en_n |-> !tx_data);
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (tx_en_n && $past(!tx_en_n)));
   assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en_n && !tick) |=> $stable(tx_data));
   assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !tx_en_n && !tick) |=> (!tx_en_n && $stable(rd_addr)));

endmodule

// File: tb/sim_balsym_framer.sv
module sim_balsym_framer;
   localparam int PERIOD = 10;
   localparam int DIV    = 4;
   localparam int HOLD   = 6;
   localparam int MAXB   = 27;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] pre = 8'd0;
   logic [7:0] wake = 8'd0;
   logic [4:0] rd_addr;
   logic [7:0] rd_data;
   logic       tx_data, tx_en_n, done;

   always #(PERIOD/2) clk = ~clk;

   logic [7:0] mem [0:31];
   always_ff @(posedge clk) rd_data <= mem[rd_addr];

   balsym_framer #(.CLK_DIV(DIV), .MAX_BYTES(MAXB), .HOLD_CYCLES(HOLD),
                   .PRE_W(8), .WAKE_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .pre_cycles(pre),
      .wake_units(wake), .rd_addr(rd_addr), .rd_data(rd_data),
      .tx_data(tx_data), .tx_en_n(tx_en_n), .done(done)
   );

   typedef struct { logic b; string tag; } exp_t;
   exp_t expq[$];
   int n_checks = 0;
   int n_fail = 0;
   int frames_seen = 0;
   logic [11:0] tab [256];

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
      end
   endtask

   task automatic push_bits(input logic [11:0] v, input int n, input string tag);
      exp_t e;
      for (int i = n - 1; i >= 0; i--) begin
         e.b = v[i];
         e.tag = tag;
         expq.push_back(e);
      end
   endtask

   // R6 table, built from the selection rule
   task automatic make_table();
      int k;
      logic [11:0] v;
      int ones, run, best;
      k = 0;
      for (int c = 0; c < 4096; c++) begin
         v = c[11:0];
         ones = 0; run = 1; best = 1;
         for (int i = 0; i < 12; i++) ones += int'(v[i]);
         for (int i = 1; i < 12; i++) begin
            run = (v[i] == v[i-1]) ? run + 1 : 1;
            if (run > best) best = run;
         end
         if (k < 256 && ones == 6 && best <= 4 && v != 12'h555 && v != 12'hAAA) begin
            tab[k] = v;
            k++;
         end
      end
   endtask

   // Monitor: pops one expected bit per bit period, checks the frame end
   initial begin
      int ph;
      logic was_low;
      logic prev_end;
      exp_t e;
      ph = 0; was_low = 1'b0; prev_end = 1'b0;
      forever begin
         @(negedge clk);
         if (!rst_n) begin
            ph = 0; was_low = 1'b0; prev_end = 1'b0;
         end else if (!tx_en_n) begin
            if (ph == DIV/2) begin
               if (expq.size() == 0) check(1'b0, "R1", "bit beyond frame", int'(tx_data), -1);
               else begin
                  e = expq.pop_front();
                  check(tx_data === e.b, e.tag, "serial bit", int'(tx_data), int'(e.b));
               end
            end
            ph = (ph + 1) % DIV;
            was_low = 1'b1;
            prev_end = 1'b0;
         end else begin
            if (prev_end) check(done === 1'b0, "R9", "done width", int'(done), 0);
            prev_end = 1'b0;
            if (was_low) begin
               check(done === 1'b1, "R9", "done at end", int'(done), 1);
               check(tx_data === 1'b0, "R9", "data when disabled", int'(tx_data), 0);
               check(expq.size() == 0, "R1", "bits missing", expq.size(), 0);
               frames_seen++;
               prev_end = 1'b1;
            end
            ph = 0;
            was_low = 1'b0;
         end
      end
   end

   // Driver: predicts the frame from mem, then strobes start
   task automatic send_frame(input int pre_v, input int wake_v, input int poke);
      int n, p, f;
      logic [7:0] sum;
      for (int w = 0; w < wake_v; w++) begin
         for (int c = 0; c < HOLD; c++) push_bits(12'b01, 2, "R4");
         push_bits(12'h01B, 8, "R4");
      end
      p = (pre_v == 0) ? 1 : pre_v;
      for (int c = 0; c < p; c++) push_bits(12'b01, 2, "R3");
      push_bits(12'h0E4, 8, "R5");
      n = int'(mem[0][4:0]);
      if (n > MAXB) n = MAXB;
      sum = 8'd0;
      for (int i = 0; i <= n; i++) begin
         push_bits(tab[mem[i]], 12, (i == 0) ? "R6" : "R7");
         sum = sum + mem[i];
      end
      push_bits(tab[sum], 12, "R8");
      f = frames_seen;
      @(negedge clk);
      pre = 8'(pre_v);
      wake = 8'(wake_v);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(tx_en_n === 1'b0, "R1", "enable after start", int'(tx_en_n), 0);
      if (poke > 0) begin
         repeat (poke) @(negedge clk);
         pre = 8'd1;
         wake = 8'd0;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         check(tx_en_n === 1'b0, "R10", "enable after mid-frame start", int'(tx_en_n), 0);
      end
      while (frames_seen == f) @(negedge clk);
      repeat (3) @(negedge clk);
      check(tx_en_n === 1'b1, "R10", "no restart after frame", int'(tx_en_n), 1);
   endtask

   bit finished = 1'b0;

   initial begin
      make_table();
      for (int i = 0; i < 32; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      check(tx_en_n === 1'b1, "R1", "reset enable", int'(tx_en_n), 1);
      check(tx_data === 1'b0, "R1", "reset data", int'(tx_data), 0);
      check(done === 1'b0, "R1", "reset done", int'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R7 R8: short packet, three data bytes
      mem[0] = 8'h03; mem[1] = 8'h00; mem[2] = 8'h5A; mem[3] = 8'hFF;
      send_frame(3, 0, 0);

      // R3 R7: zero preamble count, empty packet
      mem[0] = 8'h00;
      send_frame(0, 0, 0);

      // R4: two wake-up units with hold markers
      mem[0] = 8'h01; mem[1] = 8'hA5;
      send_frame(2, 2, 0);

      // R7 limit of count field, R10 start during the frame
      mem[0] = 8'h1F;
      for (int i = 1; i < 32; i++) mem[i] = 8'(i * 37 + 11);
      send_frame(5, 1, 40);

      // R8 checksum wrap with full packet and the default preamble length
      mem[0] = 8'h1B;
      for (int i = 1; i < 32; i++) mem[i] = 8'(8'hE0 + i);
      send_frame(160, 0, 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog expired: got 0 expected 1");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule